// File: doc/BRIEF.md
# Pixel Hit Word Formatter and Lane Serializer

This block sits between a pixel readout core and its output lanes. It takes one 23-bit hit word (row, column, timestamp and ADC fields) and builds a 24-bit transmit word from it. The column field is re-encoded, and a constant marker bit is placed at the lowest position. Together these keep real data from ever holding thirteen zeros in a row. The word is then spread over 6, 4, 2 or 1 serial lanes, as chosen by a static configuration input, and shifted out one bit per clock.

The bit clock is divided by the word period (4, 6, 12 or 24 cycles) to make a slow strobe for the core. A hit is taken over a valid/ready handshake in the strobe cycle, at most one hit per word period. When no hit is offered, when software asks for one, or before the far end has acknowledged the link, a sync/status word is sent in place of data. The sync word is a marker bit, thirteen zeros and ten status bits. A one-cycle pulse marks the first bit of every word.

Top module: `pix_word_serializer`

## Requirements
- R1: A data word has bit 0 = 1, bits 3:1 = hit[22:20] (ADC), bits 11:4 = hit[19:12] (timestamp), bits 16:12 = encoded column, and bits 23:17 = hit[6:0] (row). The raw column is hit[11:7].
- R2: A column c whose two low bits are not both 0 is sent unchanged. Otherwise it is sent as {1,1,c[2],~c[4],~c[3]} (bit 16 down to bit 12), which maps 0→27, 4→31, 8→26, 12→30, 16→25 and 20→29.
- R3: lane_cfg_i selects 0→6 lanes of 4 bits, 1→4 lanes of 6 bits, 2→2 lanes of 12 bits, or 3→1 lane of 24 bits. core_strobe_o is high for one cycle in every N cycles, where N is the number of bits per lane. It is also high in the first cycle after reset.
- R4: Lane k carries word bits k·N to k·N+N−1, lowest index first, one bit per clock. Word bit 0 therefore leads on lane 0. Lanes not used by the configuration stay at 0.
- R5: A sync/status word has bit 0 = 1, bits 13:1 = 0, and bits 23:14 = status_i as sampled in the strobe cycle that loads the word.
- R6: If hit_valid_i is low in a strobe cycle, the next word is a sync/status word.
- R7: If sync_req_i is high in a strobe cycle, the next word is a sync/status word and hit_ready_o stays low. A request in any other cycle is held and served at the next word boundary.
- R8: After reset, only sync/status words are sent, and hit_ready_o stays low, until link_ack_i has been seen high at a clock edge. The acknowledge then stays in force until the next reset.
- R9: hit_ready_o is high only in a strobe cycle. A hit accepted with hit_valid_i and hit_ready_o both high is sent in the next word period.
- R10: word_start_o is high in the cycle after each strobe, which is the cycle where word bit 0 appears on lane 0.
- R11: While rst_ni is low, lane_o, word_start_o and hit_ready_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_cfg_i | input | 2 | Static lane-count selection |
| hit_i | input | 23 | Core hit word |
| hit_valid_i | input | 1 | Core hit word is valid |
| hit_ready_o | output | 1 | Hit accepted this cycle when valid |
| sync_req_i | input | 1 | Request for a sync/status word |
| link_ack_i | input | 1 | Receiver has locked to the word boundary |
| status_i | input | 10 | Status bits placed in sync words |
| core_strobe_o | output | 1 | Word-rate strobe for the core |
| word_start_o | output | 1 | First bit of a word is on the lanes |
| lane_o | output | 6 | Serial lane outputs, lane 0 at bit 0 |

## Verification
The assertions check the following on every cycle: the marker bit is on lane 0 whenever word_start_o is high, word_start_o follows each strobe, the strobe period matches the configuration, unused lanes stay low, and ready never rises without a strobe, without a prior acknowledge, or while a sync request is present. What the assertions cannot show is the content of each word. That covers the field placement, the six rewritten columns, status capture, and the deferral of a mid-word request to the next boundary. The bench's reference model shows these by rebuilding every word from the lanes in all four configurations, with valid gaps, request pulses and a late acknowledge.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
  localparam int HitW   = 23;
  localparam int WordW  = 24;
  localparam int StatW  = 10;
  localparam int ColW   = 5;
  localparam int MaxLn  = 6;
  localparam int PosW   = $clog2(WordW);

  typedef enum logic [1:0] {
    LN_SIX  = 2'd0,
    LN_FOUR = 2'd1,
    LN_TWO  = 2'd2,
    LN_ONE  = 2'd3
  } lane_cfg_e;

  function automatic logic [PosW-1:0] bits_per_lane(input logic [1:0] cfg);
    case (cfg)
      LN_SIX:  return PosW'(4);
      LN_FOUR: return PosW'(6);
      LN_TWO:  return PosW'(12);
      default: return PosW'(24);
    endcase
  endfunction

  function automatic logic [2:0] lanes_used(input logic [1:0] cfg);
    case (cfg)
      LN_SIX:  return 3'd6;
      LN_FOUR: return 3'd4;
      LN_TWO:  return 3'd2;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/pixser_col_enc.sv
module pixser_col_enc
  import pixser_pkg::*;
(
  input  logic [ColW-1:0] col_i,
  output logic [ColW-1:0] enc_o
);
  // keep a 1 in the two low bits so no data word holds a long zero run
  always_comb begin
    if (col_i[1:0] == 2'b00) enc_o = {1'b1, 1'b1, col_i[2], ~col_i[4], ~col_i[3]};
    else                     enc_o = col_i;
  end
endmodule

// File: rtl/pixser_word_fmt.sv
module pixser_word_fmt
  import pixser_pkg::*;
(
  input  logic [HitW-1:0]  hit_i,
  input  logic [StatW-1:0] status_i,
  input  logic             sel_sync_i,
  output logic [WordW-1:0] word_o
);
  logic [ColW-1:0] col_enc;

  pixser_col_enc i_col_enc (
    .col_i (hit_i[11:7]),
    .enc_o (col_enc)
  );

  logic [WordW-1:0] data_word, sync_word;

  assign data_word = {hit_i[6:0], col_enc, hit_i[19:12], hit_i[22:20], 1'b1};
  assign sync_word = {status_i, {(WordW-StatW-1){1'b0}}, 1'b1};
  assign word_o    = sel_sync_i ? sync_word : data_word;
endmodule

// File: rtl/pixser_bit_ctr.sv
module pixser_bit_ctr
  import pixser_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PosW-1:0] bpl_i,
  output logic [PosW-1:0] pos_o,
  output logic            last_o,
  output logic            started_o
);
  logic [PosW-1:0] pos_q;
  logic            started_q;

  // reset parks the count at the top so the first cycle is a boundary
  assign last_o = (pos_q >= bpl_i - PosW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= PosW'(WordW - 1);
      started_q <= 1'b0;
    end else if (last_o) begin
      pos_q     <= '0;
      started_q <= 1'b1;
    end else begin
      pos_q     <= pos_q + PosW'(1);
    end
  end

  assign pos_o     = pos_q;
  assign started_o = started_q;
endmodule

// File: rtl/pixser_lane_mux.sv
module pixser_lane_mux
  import pixser_pkg::*;
(
  input  logic [WordW-1:0] word_i,
  input  logic [PosW-1:0]  bpl_i,
  input  logic [PosW-1:0]  pos_i,
  input  logic [2:0]       lanes_i,
  output logic [MaxLn-1:0] lane_o
);
  localparam int IdxW = PosW + 3;

  for (genvar k = 0; k < MaxLn; k++) begin : g_lane
    logic [IdxW-1:0] idx;
    assign idx = IdxW'(k) * IdxW'(bpl_i) + IdxW'(pos_i);
    always_comb begin
      if ((3'(k) < lanes_i) && (idx < IdxW'(WordW))) lane_o[k] = word_i[idx[PosW-1:0]];
      else                                           lane_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/pix_word_serializer.sv
module pix_word_serializer
  import pixser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       lane_cfg_i,
  input  logic [HitW-1:0]  hit_i,
  input  logic             hit_valid_i,
  output logic             hit_ready_o,
  input  logic             sync_req_i,
  input  logic             link_ack_i,
  input  logic [StatW-1:0] status_i,
  output logic             core_strobe_o,
  output logic             word_start_o,
  output logic [MaxLn-1:0] lane_o
);
  logic [PosW-1:0]  bpl, pos;
  logic [2:0]       lanes;
  logic             last, started;
  logic             acked_q, pend_q, sel_sync;
  logic [WordW-1:0] next_word, tx_word_q;

  assign bpl   = bits_per_lane(lane_cfg_i);
  assign lanes = lanes_used(lane_cfg_i);

  pixser_bit_ctr i_bit_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bpl_i     (bpl),
    .pos_o     (pos),
    .last_o    (last),
    .started_o (started)
  );

  assign sel_sync    = !acked_q || pend_q || sync_req_i || !hit_valid_i;
  assign hit_ready_o = last && acked_q && !pend_q && !sync_req_i;

  pixser_word_fmt i_word_fmt (
    .hit_i      (hit_i),
    .status_i   (status_i),
    .sel_sync_i (sel_sync),
    .word_o     (next_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_word_q <= '0;
      acked_q   <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (last) tx_word_q <= next_word;
      // every boundary sends a sync or clears the way, so the hold drops there
      pend_q  <= last ? 1'b0 : (pend_q || sync_req_i);
      acked_q <= acked_q || link_ack_i;
    end
  end

  pixser_lane_mux i_lane_mux (
    .word_i  (tx_word_q),
    .bpl_i   (bpl),
    .pos_i   (pos),
    .lanes_i (lanes),
    .lane_o  (lane_o)
  );

  assign core_strobe_o = last;
  assign word_start_o  = started && (pos == '0);
endmodule

// File: rtl/pixser_chk.sv
module pixser_chk
  import pixser_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       lane_cfg_i,
  input logic             hit_ready_o,
  input logic             sync_req_i,
  input logic             link_ack_i,
  input logic             core_strobe_o,
  input logic             word_start_o,
  input logic [MaxLn-1:0] lane_o
);
  logic            ack_seen_q, have_q;
  logic [PosW:0]   per_q;
  logic [PosW-1:0] bpl;

  assign bpl = bits_per_lane(lane_cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_seen_q <= 1'b0;
      have_q     <= 1'b0;
      per_q      <= '0;
    end else begin
      ack_seen_q <= ack_seen_q || link_ack_i;
      if (core_strobe_o) begin
        have_q <= 1'b1;
        per_q  <= (PosW+1)'(1);
      end else begin
        per_q  <= per_q + (PosW+1)'(1);
      end
    end
  end

  a_r10_mark_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_start_o |-> lane_o[0]);

  a_r10_start_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_strobe_o |=> word_start_o);

  a_r3_strobe_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_strobe_o && have_q) |-> (per_q == (PosW+1)'(bpl)));

  a_r4_idle_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lane_cfg_i == LN_FOUR) |-> (lane_o[5:4] == 2'b00)) and
    ((lane_cfg_i == LN_TWO)  |-> (lane_o[5:2] == 4'b0000)) and
    ((lane_cfg_i == LN_ONE)  |-> (lane_o[5:1] == 5'b00000)));

  a_r9_ready_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_ready_o |-> core_strobe_o);

  a_r8_ready_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_ready_o |-> ack_seen_q);

  a_r7_req_blocks_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req_i |-> !hit_ready_o);
endmodule

bind pix_word_serializer pixser_chk i_pixser_chk (.*);

// File: tb/test_pix_word_serializer.sv
module test_pix_word_serializer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  lane_cfg;
  logic [22:0] hit;
  logic        hit_valid, hit_ready, sync_req, link_ack;
  logic [9:0]  status;
  logic        strobe, wstart;
  logic [5:0]  lanes;

  always #2 clk = ~clk;

  pix_word_serializer i_pix_word_serializer (
    .clk_i(clk), .rst_ni(rst_n), .lane_cfg_i(lane_cfg), .hit_i(hit),
    .hit_valid_i(hit_valid), .hit_ready_o(hit_ready), .sync_req_i(sync_req),
    .link_ack_i(link_ack), .status_i(status), .core_strobe_o(strobe),
    .word_start_o(wstart), .lane_o(lanes)
  );

  int total = 0, bad = 0;
  int cfg_n, cfg_l;

  function automatic logic [4:0] enc_ref(input logic [4:0] c);
    case (c)
      5'd0:  return 5'd27;
      5'd4:  return 5'd31;
      5'd8:  return 5'd26;
      5'd12: return 5'd30;
      5'd16: return 5'd25;
      5'd20: return 5'd29;
      default: return c;
    endcase
  endfunction

  function automatic logic [23:0] fmt_ref(input logic [22:0] h);
    logic [23:0] w;
    w[0] = 1'b1;
    w[3:1] = h[22:20];
    w[11:4] = h[19:12];
    w[16:12] = enc_ref(h[11:7]);
    w[23:17] = h[6:0];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_pos;
  bit          m_started, m_acked, m_pend, m_acc, m_data, m_strobe;
  logic [23:0] m_word;
  logic [22:0] sent_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = -1; m_started = 0; m_acked = 0; m_pend = 0; m_acc = 0; m_data = 0;
      m_word = '0; sent_q.delete();
    end else begin
      m_strobe = (m_pos < 0) || (m_pos == cfg_n - 1);
      m_acc = 0;
      if (m_strobe) begin
        if (!m_acked || m_pend || sync_req || !hit_valid) begin
          m_word = {status, 13'b0, 1'b1};
          m_data = 0;
        end else begin
          m_word = fmt_ref(hit);
          m_data = 1;
          m_acc = 1;
          sent_q.push_back(hit);
        end
        m_pend = 0; m_pos = 0; m_started = 1;
      end else begin
        m_pos++;
        if (sync_req) m_pend = 1;
      end
      if (link_ack) m_acked = 1;
    end
  end

  logic [23:0] rx;
  bit          data_before_ack;

  task automatic compare_cycle();
    bit          e_strobe, e_ready, e_start;
    logic [5:0]  e_lanes;
    logic [23:0] e_w;
    e_strobe = (m_pos < 0) || (m_pos == cfg_n - 1);
    e_ready  = e_strobe && m_acked && !m_pend && !sync_req;
    e_start  = m_started && (m_pos == 0);
    for (int k = 0; k < 6; k++)
      e_lanes[k] = (k < cfg_l && m_started) ? m_word[k*cfg_n + m_pos] : 1'b0;
    chk(strobe == e_strobe, "R3 strobe", strobe, e_strobe);
    chk(hit_ready == e_ready, "R9,R8,R7 ready", hit_ready, e_ready);
    chk(wstart == e_start, "R10 word_start", wstart, e_start);
    chk(lanes == e_lanes, "R4,R6,R7 lanes", lanes, e_lanes);
    if (m_started) begin
      for (int k = 0; k < cfg_l; k++) rx[k*cfg_n + m_pos] = lanes[k];
      if (m_pos == cfg_n - 1) begin
        chk(rx[0] == 1'b1, "R1 mark", rx[0], 1);
        if (m_data) begin
          e_w = fmt_ref(sent_q.pop_front());
          chk(rx == e_w, "R1 data word", rx, e_w);
          chk(rx[13:12] != 2'b00, "R2 column low bits", rx[16:12], e_w[16:12]);
          if (!m_acked) data_before_ack = 1;
        end else begin
          chk(rx[13:1] == 13'b0 && rx == m_word, "R5 sync word", rx, m_word);
        end
      end
    end
  endtask

  task automatic run_cfg(input logic [1:0] cfg);
    int n_cyc, col;
    lane_cfg = cfg;
    case (cfg)
      2'd0: begin cfg_n = 4;  cfg_l = 6; end
      2'd1: begin cfg_n = 6;  cfg_l = 4; end
      2'd2: begin cfg_n = 12; cfg_l = 2; end
      default: begin cfg_n = 24; cfg_l = 1; end
    endcase
    rst_n = 0; hit_valid = 1; sync_req = 0; link_ack = 0; status = 10'h2a5;
    col = 0;
    hit = {3'd5, 8'h3c, 5'(col), 7'h11};
    data_before_ack = 0;
    repeat (3) begin
      @(negedge clk);
      chk(lanes == 6'b0 && !wstart && !hit_ready, "R11 reset", {lanes, wstart, hit_ready}, 0);
    end
    @(negedge clk);
    rst_n = 1;
    n_cyc = 40 * cfg_n;
    for (int c = 0; c < n_cyc; c++) begin
      if (m_acc) begin
        col = (col + 1) % 22;
        hit = {3'($urandom), 8'($urandom), 5'(col), 7'($urandom)};
      end
      hit_valid = ($urandom % 4) != 0;
      sync_req  = ($urandom % 29) == 0;
      status    = 10'($urandom);
      link_ack  = (c == 4 * cfg_n + 1);
      #1;
      compare_cycle();
      @(negedge clk);
    end
    chk(!data_before_ack, "R8 no data before ack", data_before_ack, 0);
  endtask

  initial begin
    rst_n = 0; lane_cfg = 0;
    for (int c = 0; c < 4; c++) run_cfg(2'(c));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (R3 run hung)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule